// File: doc/BRIEF.md
# Synchronous Burst SRAM Read/Write Path

This block is a synthesizable model of a synchronous burst SRAM array, together with its clocked command path and read path. Address, write data, chip select, the two burst-start strobes, the burst-advance strobe and the write controls are all sampled on the rising clock edge. An external burst sequencer supplies each address. The block decides whether a cycle reads, writes, deselects, suspends or does nothing. Each byte lane is 9 bits wide, so the default 36-bit word has four lanes and an 18-bit word has two.

A run-time mode input selects the read timing. In pass-through mode the array output goes directly to the data port. In registered mode it first passes through a rising-edge output stage. A deselect takes the same number of stages as a read, so in registered mode the bus turns off one edge later than the deselect itself. Output enable, the sleep input and the mode input act on the outputs combinationally. A valid flag stands in for the tristate pads.

Top module: `syncburst_sram`

## Requirements
- R1: While reset is held, and after it is released with no command issued, `dout_valid` is 0 and `dout` is all zeros. Whenever `dout_valid` is 0, `dout` is zero.
- R2: With `ft_mode`=0, a read sampled at edge k shows `dout_valid`=1 with that address's word in the cycle after edge k. A four-beat burst therefore delivers its data at 2-1-1-1 cycles.
- R3: With `ft_mode`=1, a read sampled at edge k shows its word in the cycle after edge k+1. The cycle between edge k and edge k+1 is not valid from this read, and a four-beat burst delivers at 3-1-1-1 cycles.
- R4: A deselect is a start strobe (`adsp_n` or `adsc_n` low) sampled with `ce_n` high. In registered mode, the read sampled at the edge before a deselect still appears after the deselect edge. The output goes inactive only after the next edge.
- R5: A write with `gw_n`=0 stores the whole word, whatever `bw_n` and `be_n` hold.
- R6: With `gw_n`=1 and `bw_n`=0, only the lanes whose `be_n` bit is 0 are written. Lane i is `din[9i+8:9i]`. Lanes with `be_n` bit 1 keep their old contents.
- R7: A cycle started by `adsp_n`=0 is always a read, and its write controls are ignored. A cycle started by `adsc_n`=0 (with `adsp_n`=1) is a write when `gw_n`=0, or when `bw_n`=0 with at least one `be_n` bit low. `adsp_n` has priority over `adsc_n`.
- R8: During an active burst with no start strobe, `adv_n`=0 accesses the address on `addr`, while `adv_n`=1 repeats the access at the held address. With no active burst, a cycle without a start strobe is idle.
- R9: `oe_n`=1 forces `dout_valid` to 0 at once, with no clock edge needed, and lowering it restores the output.
- R10: While `zz`=1, `dout_valid` is 0 and sampled commands are ignored, so no write changes the array. The array contents are kept. After `zz` falls, the first sampled command behaves normally, and the pipeline holds no stale read.
- R11: In the cycle after an edge that sampled a write, `dout_valid` is 0 in both modes. This holds even when a registered read was due in that cycle.
- R12: `ft_mode` may change at run time. The outputs follow the newly selected path combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address from the external burst sequencer |
| din | input | DATA_W | Write data, sampled with the command |
| ce_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor-side burst start, read only, active low |
| adsc_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Whole-word write, active low |
| bw_n | input | 1 | Lane write enable, active low |
| be_n | input | DATA_W/9 | Per-lane write selects, active low |
| ft_mode | input | 1 | 0 selects pass-through reads, 1 selects registered reads |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep, active high |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_valid | output | 1 | Stand-in for the data bus being driven |

## Verification
The bench measures read latency in each mode by counting edges from the start strobe to the first valid beat. A swapped mode select or a missing output stage shifts every beat by one cycle. It sends a deselect directly after a registered read. A design that deselects in a single cycle drops that last beat. The bench also sends mixed write controls on both start strobes and checks the result through later reads: a design that lets the read-only strobe write, ignores the whole-word override, or mismasks a lane corrupts the read-back word. Sleep with a write pending, output enable toggled between edges, a write right after a registered read, suspend versus advance, and randomized traffic against a bench reference model cover the remaining paths.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } sbs_op_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode #(
  parameter int LANES = 4
) (
  input  logic             ce_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] be_n,
  input  logic             zz,
  input  logic             burst_on,
  output sbs_pkg::sbs_op_e op,
  output logic             take_addr,
  output logic [LANES-1:0] lane_we
);
  import sbs_pkg::*;

  // Lanes a write would touch: whole word overrides the lane selects.
  function automatic logic [LANES-1:0] lanes_of(input logic g_n, input logic b_n,
                                                input logic [LANES-1:0] sel_n);
    if (!g_n) return '1;
    if (!b_n) return ~sel_n;
    return '0;
  endfunction

  logic [LANES-1:0] wmask;
  logic             wants_wr;

  always_comb begin
    wmask     = lanes_of(gw_n, bw_n, be_n);
    wants_wr  = |wmask;
    op        = OP_IDLE;
    take_addr = 1'b0;
    if (zz) begin
      op = OP_IDLE;
    end else if (!adsp_n) begin
      take_addr = 1'b1;
      op        = ce_n ? OP_DESEL : OP_READ;
    end else if (!adsc_n) begin
      take_addr = 1'b1;
      op        = ce_n ? OP_DESEL : (wants_wr ? OP_WRITE : OP_READ);
    end else if (burst_on) begin
      take_addr = !adv_n;
      op        = wants_wr ? OP_WRITE : OP_READ;
    end
    lane_we = (op == OP_WRITE) ? wmask : '0;
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic [DATA_W/LANE_W-1:0] we_lanes,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [DATA_W-1:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bit_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bit_we[g*LANE_W +: LANE_W] = {LANE_W{we_lanes[g]}};
  end

  always_ff @(posedge clk) begin
    if (|we_lanes) mem[waddr] <= (mem[waddr] & ~bit_we) | (wdata & bit_we);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sbs_read_out.sv
module sbs_read_out #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zz,
  input  logic              flow,
  input  logic              oe_n,
  input  logic              rd_now,
  input  logic              wr_now,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  logic              pv_q;
  logic [DATA_W-1:0] pd_q;
  logic              slot_v;
  logic [DATA_W-1:0] slot_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pd_q <= '0;
    end else if (zz) begin
      pv_q <= 1'b0;
    end else begin
      pv_q <= rd_now;
      if (rd_now) pd_q <= arr_data;
    end
  end

  always_comb begin
    slot_v     = flow ? rd_now : pv_q;
    slot_d     = flow ? arr_data : pd_q;
    dout_valid = slot_v & ~wr_now & ~zz & ~oe_n;
    dout       = dout_valid ? slot_d : '0;
  end
endmodule

// File: rtl/syncburst_sram.sv
module syncburst_sram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        din,
  input  logic                     ce_n,
  input  logic                     adsp_n,
  input  logic                     adsc_n,
  input  logic                     adv_n,
  input  logic                     gw_n,
  input  logic                     bw_n,
  input  logic [DATA_W/LANE_W-1:0] be_n,
  input  logic                     ft_mode,
  input  logic                     oe_n,
  input  logic                     zz,
  output logic [DATA_W-1:0]        dout,
  output logic                     dout_valid
);
  import sbs_pkg::*;
  localparam int LANES = DATA_W / LANE_W;

  sbs_op_e           op;
  logic              take_addr;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] op_addr;
  logic [ADDR_W-1:0] addr_hold;
  logic [ADDR_W-1:0] raddr_q;
  logic              burst_on;
  logic              rd_evt;
  logic              wr_evt;
  logic              flow_sel;
  logic              access;
  logic [DATA_W-1:0] arr_data;

  assign flow_sel = ~ft_mode;
  assign op_addr  = take_addr ? addr : addr_hold;
  assign access   = (op == OP_READ) || (op == OP_WRITE);

  sbs_cmd_decode #(.LANES(LANES)) u_dec (
    .ce_n(ce_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n), .zz(zz), .burst_on(burst_on),
    .op(op), .take_addr(take_addr), .lane_we(lane_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_evt    <= 1'b0;
      wr_evt    <= 1'b0;
      raddr_q   <= '0;
      addr_hold <= '0;
      burst_on  <= 1'b0;
    end else begin
      rd_evt <= (op == OP_READ);
      wr_evt <= (op == OP_WRITE);
      if (access) begin
        raddr_q   <= op_addr;
        addr_hold <= op_addr;
      end
      if (zz || op == OP_DESEL) burst_on <= 1'b0;
      else if (access)          burst_on <= 1'b1;
    end
  end

  sbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .we_lanes(lane_we), .waddr(op_addr), .wdata(din),
    .raddr(raddr_q), .rdata(arr_data)
  );

  sbs_read_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .zz(zz), .flow(flow_sel), .oe_n(oe_n),
    .rd_now(rd_evt), .wr_now(wr_evt), .arr_data(arr_data),
    .dout(dout), .dout_valid(dout_valid)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_n,
  input logic              zz,
  input logic              ce_n,
  input logic              adsp_n,
  input logic              flow_sel,
  input logic              rd_evt,
  input logic              wr_evt,
  input logic              dout_valid,
  input logic [DATA_W-1:0] dout
);
  // R1
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == '0));
  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_valid);
  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz |-> !dout_valid);
  // R10
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> (!rd_evt && !wr_evt));
  // R11
  write_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> !dout_valid);
  // R7
  adsp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce_n && !zz) |=> (rd_evt && !wr_evt));
  // R3
  reg_path_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_sel && dout_valid) |-> $past(rd_evt));
endmodule

bind syncburst_sram sbs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .zz(zz), .ce_n(ce_n),
  .adsp_n(adsp_n), .flow_sel(flow_sel), .rd_evt(rd_evt), .wr_evt(wr_evt),
  .dout_valid(dout_valid), .dout(dout)
);

// File: tb/syncburst_sram_tb.sv
module syncburst_sram_tb;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int LW = 9;
  localparam int NL = DW / LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic ce_n = 1'b1, adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bw_n = 1'b1;
  logic [NL-1:0] be_n = '1;
  logic ft_mode = 1'b1, oe_n = 1'b0, zz = 1'b0;
  logic [DW-1:0] dout;
  logic dout_valid;

  always #5 clk = ~clk;

  syncburst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
    .bw_n(bw_n), .be_n(be_n), .ft_mode(ft_mode), .oe_n(oe_n), .zz(zz),
    .dout(dout), .dout_valid(dout_valid)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] ref_mem [DEPTH];
  logic          m_rd = 0, m_wr = 0, m_pv = 0, m_burst = 0;
  logic [DW-1:0] m_pd = '0;
  logic [AW-1:0] m_raddr = '0, m_hold = '0;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
      input logic [DW-1:0] new_w, input logic [NL-1:0] keep_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < NL; i++)
      if (!keep_n[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW:0] expect_out();
    logic v;
    logic [DW-1:0] d;
    v = !oe_n && !zz && !m_wr && (ft_mode ? m_pv : m_rd);
    d = ft_mode ? m_pd : ref_mem[m_raddr];
    return {v, v ? d : {DW{1'b0}}};
  endfunction

  task automatic model_edge();
    logic [DW-1:0] old_rd;
    logic [NL-1:0] wsel_n;
    logic is_w, is_r, tk, desel;
    logic [AW-1:0] a;
    old_rd = ref_mem[m_raddr];
    if (zz) m_pv = 0;
    else begin
      m_pv = m_rd;
      if (m_rd) m_pd = old_rd;
    end
    wsel_n = !gw_n ? '0 : (!bw_n ? be_n : '1);
    is_w = 0; is_r = 0; tk = 0; desel = 0;
    if (!zz) begin
      if (!adsp_n) begin tk = 1; desel = ce_n; is_r = !ce_n; end
      else if (!adsc_n) begin
        tk = 1; desel = ce_n;
        is_w = !ce_n && (wsel_n != '1); is_r = !ce_n && (wsel_n == '1);
      end else if (m_burst) begin
        tk = !adv_n; is_w = (wsel_n != '1); is_r = !is_w;
      end
    end
    a = tk ? addr : m_hold;
    if (is_w) ref_mem[a] = lane_merge(ref_mem[a], din, wsel_n);
    m_rd = is_r; m_wr = is_w;
    if (is_r || is_w) begin m_raddr = a; m_hold = a; m_burst = 1; end
    if (desel || zz) m_burst = 0;
  endtask

  task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
               tag, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
    end
  endtask

  task automatic cmp_model(input string tag);
    check(tag, {dout_valid, dout}, expect_out());
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp_model(tag);
  endtask

  task automatic idle_in();
    ce_n = 1; adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; be_n = '1;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    idle_in(); ce_n = 0; adsp_n = 0; addr = a;
    tick(tag);
  endtask

  task automatic deselect(input string tag);
    idle_in(); adsp_n = 0;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual run still going, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] keep, wv;
    void'($urandom(32'd4321));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {dout_valid, dout}, '0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {dout_valid, dout}, '0);

    // preload full words through whole-word writes (R5)
    for (int i = 0; i < DEPTH; i++) begin
      idle_in(); ce_n = 0; adsc_n = 0; gw_n = 0; addr = i[AW-1:0];
      din = {$urandom, $urandom};
      tick("R5 preload");
    end
    deselect("R4");

    // R2: pass-through burst, 2-1-1-1
    ft_mode = 0;
    do_read(6'd5, "R2");
    check("R2 first beat", {dout_valid, dout}, {1'b1, ref_mem[5]});
    for (int b = 1; b < 4; b++) begin
      idle_in(); adv_n = 0; addr = 6'(5 + b);
      tick("R2");
      check("R2 burst beat", {dout_valid, dout}, {1'b1, ref_mem[5+b]});
    end
    deselect("R2");
    check("R2 off after deselect", {dout_valid, dout}, '0);

    // R3: registered burst, 3-1-1-1; R4 dual-cycle deselect
    ft_mode = 1; idle_in(); tick("R3");
    do_read(6'd10, "R3");
    check("R3 no data after first edge", {dout_valid, dout}, '0);
    for (int b = 1; b < 4; b++) begin
      idle_in(); adv_n = 0; addr = 6'(10 + b);
      tick("R3");
      check("R3 beat", {dout_valid, dout}, {1'b1, ref_mem[10+b-1]});
    end
    deselect("R4");
    check("R4 last beat held", {dout_valid, dout}, {1'b1, ref_mem[13]});
    idle_in(); tick("R4");
    check("R4 off after second edge", {dout_valid, dout}, '0);

    // R5 / R6 / R7 writes, read back in pass-through mode
    ft_mode = 0;
    wv = {$urandom, $urandom};
    idle_in(); ce_n = 0; adsc_n = 0; gw_n = 0; bw_n = 0; be_n = '1; addr = 20; din = wv;
    tick("R5");
    do_read(6'd20, "R5");
    check("R5 whole word", {dout_valid, dout}, {1'b1, wv});
    keep = ref_mem[21]; wv = {$urandom, $urandom};
    idle_in(); ce_n = 0; adsc_n = 0; bw_n = 0; be_n = 4'b1010; addr = 21; din = wv;
    tick("R6");
    do_read(6'd21, "R6");
    check("R6 lanes 0,2", {dout_valid, dout}, {1'b1, lane_merge(keep, wv, 4'b1010)});
    keep = ref_mem[22];
    idle_in(); ce_n = 0; adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 22; din = ~keep;
    tick("R7");
    check("R7 adsp reads", {dout_valid, dout}, {1'b1, keep});
    do_read(6'd22, "R7");
    check("R7 no write", {dout_valid, dout}, {1'b1, keep});

    // R8 suspend vs advance vs idle
    do_read(6'd30, "R8");
    idle_in(); addr = 31; tick("R8");
    check("R8 suspend repeats", {dout_valid, dout}, {1'b1, ref_mem[30]});
    idle_in(); adv_n = 0; addr = 33; tick("R8");
    check("R8 advance", {dout_valid, dout}, {1'b1, ref_mem[33]});
    deselect("R8");
    idle_in(); adv_n = 0; addr = 34; tick("R8");
    check("R8 idle without burst", {dout_valid, dout}, '0);

    // R9 asynchronous output enable
    do_read(6'd35, "R9");
    oe_n = 1; #1;
    check("R9 oe off", {dout_valid, dout}, '0);
    oe_n = 0; #1;
    check("R9 oe on", {dout_valid, dout}, {1'b1, ref_mem[35]});

    // R10 sleep
    keep = ref_mem[40];
    zz = 1; #1;
    check("R10 sleep quiet", {dout_valid, dout}, '0);
    idle_in(); ce_n = 0; adsc_n = 0; gw_n = 0; addr = 40; din = ~keep;
    tick("R10");
    zz = 0; ft_mode = 1; idle_in(); #1;
    check("R10 no stale read", {dout_valid, dout}, '0);
    ft_mode = 0;
    do_read(6'd40, "R10");
    check("R10 contents kept", {dout_valid, dout}, {1'b1, keep});

    // R11 write after registered read
    ft_mode = 1; deselect("R11"); idle_in(); tick("R11");
    do_read(6'd50, "R11");
    idle_in(); ce_n = 0; adsc_n = 0; gw_n = 0; addr = 51; din = {$urandom, $urandom};
    tick("R11");
    check("R11 turnaround", {dout_valid, dout}, '0);

    // R12 run-time mode change
    deselect("R12"); idle_in(); tick("R12");
    do_read(6'd52, "R12");
    ft_mode = 0; #1;
    check("R12 switch to pass-through", {dout_valid, dout}, {1'b1, ref_mem[52]});
    ft_mode = 1; #1;
    check("R12 back to registered", {dout_valid, dout}, '0);

    // random traffic against the model (R2 R3 R6 R8 R10 R11)
    for (int c = 0; c < 3000; c++) begin
      ce_n   = ($urandom % 6) == 0;
      adsp_n = ($urandom % 4) != 0;
      adsc_n = ($urandom % 4) != 0;
      adv_n  = $urandom % 2;
      gw_n   = ($urandom % 5) != 0;
      bw_n   = ($urandom % 3) != 0;
      be_n   = NL'($urandom);
      addr   = AW'($urandom);
      din    = {$urandom, $urandom};
      ft_mode = ($urandom % 8) != 0 ? ft_mode : ~ft_mode;
      oe_n   = ($urandom % 10) == 0;
      zz     = ($urandom % 25) == 0;
      tick("R3 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule